// File: doc/BRIEF.md
# Byte-Serial Instruction Length Parser

This block takes a stream of code bytes, one per cycle, and splits it into variable-length CISC instructions. It walks each instruction through five phases. The first phase collects up to `MAX_PFX` prefix bytes. The second is a one- or two-byte opcode, where a fixed escape byte announces the second byte. An optional mode/register/memory specifier follows, with an optional scale-index byte after it. The last two phases are an optional displacement and an optional immediate. Address-size and operand-size prefixes change how long the later fields are.

For each instruction the block emits one descriptor. The descriptor gives the total byte count, the prefix flags, the opcode, and the size of every field. The field boundaries follow from these sizes because the fields always appear in the order prefixes, opcode, specifier, scale-index, displacement, immediate. The parser does not assign any meaning to opcodes. Its only per-opcode knowledge is a small property rule:
- one opcode bit selects whether a specifier is present;
- the two low opcode bits index a four-entry immediate-class table.

The stream side uses a valid/ready handshake. The descriptor side is a single registered slot that the consumer drains with its own ready signal.

Top module: `vlp_parse`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0, and `in_ready` is 1 until a descriptor is pending.
- R2: `in_ready` is 1 exactly when no descriptor is pending or `out_ready` is 1. A pending descriptor that is not accepted stays valid and unchanged.
- R3: Each prefix byte is counted in `out_pfx_cnt` and sets its flag, as follows:
  - F0 sets `out_lock`.
  - F2 sets `out_rep` to 1 and F3 sets it to 2. The last repeat byte wins.
  - 2E, 36, 3E, 26, 64 and 65 set `out_seg` to 1 through 6 respectively. The last segment byte wins.
  - 66 sets `out_opsz`.
  - 67 sets `out_adsz`.
- R4: A 0F byte where the opcode is expected sets `out_two_byte` and makes the next byte the opcode. `out_opcode` always holds the final opcode byte.
- R5: A specifier byte follows the opcode exactly when bit 2 of the final opcode byte is 1.
- R6: A scale-index byte follows the specifier exactly when all three hold: `out_adsz` is 0, the mode field (bits 7:6) is not 3, and the r/m field (bits 2:0) is 4.
- R7: The displacement length depends on the addressing size.
  - Without the address-size prefix: mode 0 with r/m 5 gives 4 bytes, mode 1 gives 1, mode 2 gives 4, and every other case gives 0.
  - With the address-size prefix: mode 0 with r/m 6 gives 2 bytes, mode 1 gives 1, mode 2 gives 2, and every other case gives 0.
  - An instruction with no specifier has no displacement.
- R8: Opcode bits 1:0 select the immediate length:
  - 00 gives none;
  - 01 gives 1 byte;
  - 10 gives 4 bytes, or 2 when the operand-size prefix is present;
  - 11 gives 2 bytes.
- R9: `out_len` equals the number of bytes consumed by the instruction. That is the prefix count, plus 1 or 2 opcode bytes, plus the specifier, scale-index, displacement and immediate lengths.
- R10: The prefix byte numbered `MAX_PFX`+1 ends the instruction with `out_err`=1. In that descriptor, `out_len` and `out_pfx_cnt` both equal `MAX_PFX`+1, and all opcode and field outputs are 0. The next byte starts a new instruction.
- R11: A descriptor becomes valid in the cycle after its last byte is accepted. Instructions can be accepted back to back without idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A code byte is offered |
| in_data | input | 8 | Code byte |
| in_ready | output | 1 | Parser accepts the offered byte |
| out_valid | output | 1 | Descriptor pending |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_len | output | LEN_W | Total instruction length in bytes |
| out_err | output | 1 | Too many prefixes |
| out_pfx_cnt | output | PFX_W | Number of prefix bytes |
| out_lock | output | 1 | Bus-lock prefix seen |
| out_rep | output | 2 | Repeat prefix: 0 none, 1 F2, 2 F3 |
| out_seg | output | 3 | Segment override code, 0 for none |
| out_opsz | output | 1 | Operand-size override seen |
| out_adsz | output | 1 | Address-size override seen |
| out_two_byte | output | 1 | Escape byte preceded the opcode |
| out_opcode | output | 8 | Final opcode byte |
| out_has_modrm | output | 1 | Specifier byte present |
| out_has_sib | output | 1 | Scale-index byte present |
| out_disp_len | output | 3 | Displacement bytes (0, 1, 2 or 4) |
| out_imm_len | output | 3 | Immediate bytes (0, 1, 2 or 4) |

## Verification
A wrong phase or a wrong remaining-byte count inside the parser does not stay hidden. The next descriptor arrives too early or too late, and from then on every later instruction is framed at the wrong byte. A reference model that parses the same stream therefore sees a length or field mismatch on the very next descriptor. A corrupted prefix accumulator appears as a wrong flag, or as a wrong immediate or displacement length, in the descriptor of the instruction it belongs to. A slip in the output slot appears within one cycle as a lost, repeated or early descriptor.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

   // Prefix byte codes
   localparam logic [7:0] PB_LOCK  = 8'hF0;
   localparam logic [7:0] PB_REPNE = 8'hF2;
   localparam logic [7:0] PB_REPE  = 8'hF3;
   localparam logic [7:0] PB_OPSZ  = 8'h66;
   localparam logic [7:0] PB_ADSZ  = 8'h67;
   localparam int         SEG_N    = 6;

   typedef enum logic [2:0] {
      PK_NONE,
      PK_LOCK,
      PK_REP,
      PK_SEG,
      PK_OPSZ,
      PK_ADSZ
   } pfx_kind_e;

   typedef enum logic [1:0] {
      IMM_NONE,
      IMM_BYTE,
      IMM_WORD,
      IMM_HALF
   } imm_cls_e;

   typedef enum logic [2:0] {
      ST_PFX,
      ST_OP2,
      ST_SPEC,
      ST_SIB,
      ST_DISP,
      ST_IMM
   } state_e;

   typedef struct packed {
      logic       lock;
      logic [1:0] rep;
      logic [2:0] seg;
      logic       opsz;
      logic       adsz;
   } pfx_flags_t;

   typedef struct packed {
      logic       err;
      pfx_flags_t flags;
      logic       two_byte;
      logic [7:0] opcode;
      logic       has_spec;
      logic       has_sib;
      logic [2:0] disp_len;
      logic [2:0] imm_len;
   } desc_fields_t;

   // Immediate byte count for a class, given the operand-size override
   function automatic logic [2:0] imm_bytes(imm_cls_e cls, logic opsz);
      logic [2:0] n;
      case (cls)
         IMM_BYTE: n = 3'd1;
         IMM_WORD: n = opsz ? 3'd2 : 3'd4;
         IMM_HALF: n = 3'd2;
         default:  n = 3'd0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/vlp_prefix_class.sv
module vlp_prefix_class
   import vlp_pkg::*;
(
   input  logic [7:0] byte_i,
   output logic       is_pfx_o,
   output pfx_kind_e  kind_o,
   output logic [2:0] code_o
);

   // Segment override bytes; code reported is position + 1
   localparam logic [7:0] SEG_TBL [SEG_N] = '{8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65};

   logic [SEG_N-1:0] seg_hit;

   for (genvar g = 0; g < SEG_N; g++) begin : g_seg
      assign seg_hit[g] = (byte_i == SEG_TBL[g]);
   end

   always_comb begin
      kind_o = PK_NONE;
      code_o = 3'd0;
      if (|seg_hit) begin
         kind_o = PK_SEG;
         for (int i = 0; i < SEG_N; i++) begin
            if (seg_hit[i]) code_o = 3'(i + 1);
         end
      end else begin
         case (byte_i)
            PB_LOCK:  kind_o = PK_LOCK;
            PB_REPNE: begin kind_o = PK_REP; code_o = 3'd1; end
            PB_REPE:  begin kind_o = PK_REP; code_o = 3'd2; end
            PB_OPSZ:  kind_o = PK_OPSZ;
            PB_ADSZ:  kind_o = PK_ADSZ;
            default:  kind_o = PK_NONE;
         endcase
      end
   end

   assign is_pfx_o = (kind_o != PK_NONE);

endmodule

// File: rtl/vlp_opcode_props.sv
module vlp_opcode_props
   import vlp_pkg::*;
#(
   parameter logic [7:0] IMM_MAP  = 8'b11_10_01_00,
   parameter int         SPEC_BIT = 2
) (
   input  logic [7:0] opc_i,
   input  logic       opsz_i,
   output logic       spec_o,
   output logic [2:0] imm_len_o
);

   localparam int ENTRIES = 4;

   if (SPEC_BIT < 2 || SPEC_BIT > 7) begin : g_bad_spec
      $error("SPEC_BIT must lie outside the immediate index bits");
   end

   logic [3*ENTRIES-1:0] len_flat;
   logic [7:0]           opc_unused;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign len_flat[3*g +: 3] = imm_bytes(imm_cls_e'(IMM_MAP[2*g +: 2]), opsz_i);
   end

   assign imm_len_o  = len_flat[3*opc_i[1:0] +: 3];
   assign spec_o     = opc_i[SPEC_BIT];
   assign opc_unused = opc_i;

endmodule

// File: rtl/vlp_spec_decode.sv
module vlp_spec_decode (
   input  logic [7:0] spec_i,
   input  logic       adsz_i,
   output logic       sib_o,
   output logic [2:0] disp_len_o
);

   logic [1:0] mode;
   logic [2:0] rm;
   logic [2:0] reg_unused;

   assign mode       = spec_i[7:6];
   assign rm         = spec_i[2:0];
   assign reg_unused = spec_i[5:3];

   assign sib_o = !adsz_i && (mode != 2'b11) && (rm == 3'd4);

   always_comb begin
      case (mode)
         2'd0: begin
            if (adsz_i) disp_len_o = (rm == 3'd6) ? 3'd2 : 3'd0;
            else        disp_len_o = (rm == 3'd5) ? 3'd4 : 3'd0;
         end
         2'd1:    disp_len_o = 3'd1;
         2'd2:    disp_len_o = adsz_i ? 3'd2 : 3'd4;
         default: disp_len_o = 3'd0;
      endcase
   end

endmodule

// File: rtl/vlp_parse.sv
module vlp_parse
   import vlp_pkg::*;
#(
   parameter int         MAX_PFX  = 4,
   parameter logic [7:0] IMM_MAP  = 8'b11_10_01_00,
   parameter int         SPEC_BIT = 2,
   parameter logic [7:0] ESC_BYTE = 8'h0F,
   localparam int        MAX_LEN  = MAX_PFX + 12,
   localparam int        LEN_W    = $clog2(MAX_LEN + 1),
   localparam int        PFX_W    = $clog2(MAX_PFX + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [LEN_W-1:0] out_len,
   output logic             out_err,
   output logic [PFX_W-1:0] out_pfx_cnt,
   output logic             out_lock,
   output logic [1:0]       out_rep,
   output logic [2:0]       out_seg,
   output logic             out_opsz,
   output logic             out_adsz,
   output logic             out_two_byte,
   output logic [7:0]       out_opcode,
   output logic             out_has_modrm,
   output logic             out_has_sib,
   output logic [2:0]       out_disp_len,
   output logic [2:0]       out_imm_len
);

   if (MAX_PFX < 1 || MAX_PFX > 14) begin : g_bad_pfx
      $error("MAX_PFX out of supported range");
   end

   // ---------------- byte classifiers ----------------
   logic       pc_is_pfx;
   pfx_kind_e  pc_kind;
   logic [2:0] pc_code;
   logic       op_spec;
   logic [2:0] op_imm;
   logic       sp_sib;
   logic [2:0] sp_disp;

   // ---------------- parse state ----------------
   state_e           state_q, state_d;
   logic [LEN_W-1:0] len_q, len_d;
   logic [PFX_W-1:0] pcnt_q, pcnt_d;
   desc_fields_t     acc_q, acc_d;
   logic [2:0]       rem_q, rem_d;
   logic             done, take_op, go_disp, go_imm;
   logic             accept;

   // ---------------- descriptor slot ----------------
   logic             ov_q;
   logic [LEN_W-1:0] olen_q;
   logic [PFX_W-1:0] opcnt_q;
   desc_fields_t     ofld_q;

   vlp_prefix_class u_pfx (
      .byte_i   (in_data),
      .is_pfx_o (pc_is_pfx),
      .kind_o   (pc_kind),
      .code_o   (pc_code)
   );

   vlp_opcode_props #(
      .IMM_MAP  (IMM_MAP),
      .SPEC_BIT (SPEC_BIT)
   ) u_ops (
      .opc_i     (in_data),
      .opsz_i    (acc_q.flags.opsz),
      .spec_o    (op_spec),
      .imm_len_o (op_imm)
   );

   vlp_spec_decode u_spec (
      .spec_i     (in_data),
      .adsz_i     (acc_q.flags.adsz),
      .sib_o      (sp_sib),
      .disp_len_o (sp_disp)
   );

   assign in_ready = !ov_q || out_ready;
   assign accept   = in_valid && in_ready;

   // Next-state computation for the byte currently offered
   always_comb begin
      acc_d   = acc_q;
      len_d   = len_q + LEN_W'(1);
      pcnt_d  = pcnt_q;
      rem_d   = rem_q;
      state_d = state_q;
      done    = 1'b0;
      take_op = 1'b0;
      go_disp = 1'b0;
      go_imm  = 1'b0;

      case (state_q)
         ST_PFX: begin
            if (pc_is_pfx) begin
               pcnt_d = pcnt_q + PFX_W'(1);
               case (pc_kind)
                  PK_LOCK: acc_d.flags.lock = 1'b1;
                  PK_REP:  acc_d.flags.rep  = pc_code[1:0];
                  PK_SEG:  acc_d.flags.seg  = pc_code;
                  PK_OPSZ: acc_d.flags.opsz = 1'b1;
                  PK_ADSZ: acc_d.flags.adsz = 1'b1;
                  default: ;
               endcase
               if (pcnt_q == PFX_W'(MAX_PFX)) begin
                  acc_d.err = 1'b1;
                  done      = 1'b1;
               end
            end else if (in_data == ESC_BYTE) begin
               acc_d.two_byte = 1'b1;
               state_d        = ST_OP2;
            end else begin
               take_op = 1'b1;
            end
         end
         ST_OP2: take_op = 1'b1;
         ST_SPEC: begin
            acc_d.has_sib  = sp_sib;
            acc_d.disp_len = sp_disp;
            if (sp_sib) state_d = ST_SIB;
            else        go_disp = 1'b1;
         end
         ST_SIB: go_disp = 1'b1;
         ST_DISP: begin
            if (rem_q == 3'd1) go_imm = 1'b1;
            else               rem_d  = rem_q - 3'd1;
         end
         ST_IMM: begin
            if (rem_q == 3'd1) done  = 1'b1;
            else               rem_d = rem_q - 3'd1;
         end
         default: state_d = ST_PFX;
      endcase

      if (take_op) begin
         acc_d.opcode   = in_data;
         acc_d.has_spec = op_spec;
         acc_d.imm_len  = op_imm;
         if (op_spec) state_d = ST_SPEC;
         else         go_imm  = 1'b1;
      end

      if (go_disp) begin
         if (acc_d.disp_len != 3'd0) begin
            state_d = ST_DISP;
            rem_d   = acc_d.disp_len;
         end else begin
            go_imm = 1'b1;
         end
      end

      if (go_imm) begin
         if (acc_d.imm_len != 3'd0) begin
            state_d = ST_IMM;
            rem_d   = acc_d.imm_len;
         end else begin
            done = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_PFX;
         len_q   <= '0;
         pcnt_q  <= '0;
         acc_q   <= '0;
         rem_q   <= '0;
         ov_q    <= 1'b0;
         olen_q  <= '0;
         opcnt_q <= '0;
         ofld_q  <= '0;
      end else begin
         if (ov_q && out_ready) ov_q <= 1'b0;
         if (accept) begin
            if (done) begin
               ov_q    <= 1'b1;
               olen_q  <= len_d;
               opcnt_q <= pcnt_d;
               ofld_q  <= acc_d;
               state_q <= ST_PFX;
               len_q   <= '0;
               pcnt_q  <= '0;
               acc_q   <= '0;
               rem_q   <= '0;
            end else begin
               state_q <= state_d;
               len_q   <= len_d;
               pcnt_q  <= pcnt_d;
               acc_q   <= acc_d;
               rem_q   <= rem_d;
            end
         end
      end
   end

   assign out_valid     = ov_q;
   assign out_len       = olen_q;
   assign out_err       = ofld_q.err;
   assign out_pfx_cnt   = opcnt_q;
   assign out_lock      = ofld_q.flags.lock;
   assign out_rep       = ofld_q.flags.rep;
   assign out_seg       = ofld_q.flags.seg;
   assign out_opsz      = ofld_q.flags.opsz;
   assign out_adsz      = ofld_q.flags.adsz;
   assign out_two_byte  = ofld_q.two_byte;
   assign out_opcode    = ofld_q.opcode;
   assign out_has_modrm = ofld_q.has_spec;
   assign out_has_sib   = ofld_q.has_sib;
   assign out_disp_len  = ofld_q.disp_len;
   assign out_imm_len   = ofld_q.imm_len;

   // ---------------- assertions ----------------
   // R2
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(ofld_q) && $stable(out_pfx_cnt));

   // R9
   len_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err |-> out_len == LEN_W'(out_pfx_cnt) + LEN_W'(1) + LEN_W'(out_two_byte)
         + LEN_W'(out_has_modrm) + LEN_W'(out_has_sib) + LEN_W'(out_disp_len) + LEN_W'(out_imm_len));

   // R9
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_q < LEN_W'(MAX_LEN));

   // R10
   err_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_err |-> out_len == LEN_W'(MAX_PFX + 1) && out_pfx_cnt == PFX_W'(MAX_PFX + 1)
         && !out_two_byte && !out_has_modrm && out_imm_len == 3'd0);

   // R6
   sib_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_has_sib |-> out_has_modrm && !out_adsz);

   // R7
   disp_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_disp_len != 3'd0 |-> out_has_modrm && (out_adsz ? out_disp_len != 3'd4 : out_disp_len != 3'd2));

   // R3
   pfx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_err |-> out_pfx_cnt <= PFX_W'(MAX_PFX));

   // R11
   new_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready));

endmodule

// File: tb/vlp_parse_bench.sv
module vlp_parse_bench;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_PFX    = 4;
   localparam int LEN_W      = 5;
   localparam int PFX_W      = 3;
   localparam int RAND_BYTES = 2500;
   localparam int CYC_LIMIT  = 100000;
   localparam int DIR_N      = 7;
   localparam int DIR_LEN [DIR_N] = '{1, 11, 3, 8, 5, 5, 3};

   typedef struct {
      int len; bit err; int pfx; bit lock; int rep; int seg; bit opsz; bit adsz;
      bit two; int opc; bit modrm; bit sib; int disp; int imm;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             in_valid;
   logic [7:0]       in_data;
   logic             in_ready;
   logic             out_valid;
   logic             out_ready;
   logic [LEN_W-1:0] out_len;
   logic             out_err;
   logic [PFX_W-1:0] out_pfx_cnt;
   logic             out_lock;
   logic [1:0]       out_rep;
   logic [2:0]       out_seg;
   logic             out_opsz;
   logic             out_adsz;
   logic             out_two_byte;
   logic [7:0]       out_opcode;
   logic             out_has_modrm;
   logic             out_has_sib;
   logic [2:0]       out_disp_len;
   logic [2:0]       out_imm_len;

   int tests_run = 0;
   int tests_failed = 0;

   logic [7:0] stream [$];
   bit         last_at [$];
   exp_t       exp_q [$];

   vlp_parse u_vlp_parse (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_err(out_err),
      .out_pfx_cnt(out_pfx_cnt), .out_lock(out_lock), .out_rep(out_rep), .out_seg(out_seg),
      .out_opsz(out_opsz), .out_adsz(out_adsz), .out_two_byte(out_two_byte),
      .out_opcode(out_opcode), .out_has_modrm(out_has_modrm), .out_has_sib(out_has_sib),
      .out_disp_len(out_disp_len), .out_imm_len(out_imm_len)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(string tag, string what, int act, int exp_v);
      tests_run++;
      if (act != exp_v) begin
         tests_failed++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp_v);
      end
   endtask

   function automatic bit is_pfx(logic [7:0] b);
      case (b)
         8'hF0, 8'hF2, 8'hF3, 8'h66, 8'h67,
         8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic int seg_code(logic [7:0] b);
      case (b)
         8'h2E: return 1;
         8'h36: return 2;
         8'h3E: return 3;
         8'h26: return 4;
         8'h64: return 5;
         8'h65: return 6;
         default: return 0;
      endcase
   endfunction

   task automatic push_bytes(input logic [7:0] b []);
      foreach (b[k]) stream.push_back(b[k]);
   endtask

   // Behavioural parse of the whole stream following R3..R10
   task automatic build_expect();
      int i;
      int n;
      i = 0;
      n = stream.size();
      for (int k = 0; k < n; k++) last_at.push_back(1'b0);
      while (i < n) begin
         exp_t e;
         int start;
         int md;
         int rm;
         logic [7:0] b;
         e = '{default: 0};
         start = i;
         while (i < n && is_pfx(stream[i]) && !e.err) begin
            b = stream[i];
            i++;
            e.pfx++;
            case (b)
               8'hF0: e.lock = 1'b1;
               8'hF2: e.rep = 1;
               8'hF3: e.rep = 2;
               8'h66: e.opsz = 1'b1;
               8'h67: e.adsz = 1'b1;
               default: e.seg = seg_code(b);
            endcase
            if (e.pfx == MAX_PFX + 1) e.err = 1'b1;
         end
         if (!e.err) begin
            if (i >= n) break;
            if (stream[i] == 8'h0F) begin e.two = 1'b1; i++; end
            if (i >= n) break;
            b = stream[i];
            i++;
            e.opc = int'(b);
            e.modrm = b[2];
            case (b[1:0])
               2'd0: e.imm = 0;
               2'd1: e.imm = 1;
               2'd2: e.imm = e.opsz ? 2 : 4;
               default: e.imm = 2;
            endcase
            if (e.modrm) begin
               if (i >= n) break;
               md = int'(stream[i][7:6]);
               rm = int'(stream[i][2:0]);
               i++;
               e.sib = !e.adsz && md != 3 && rm == 4;
               if (e.adsz) e.disp = (md == 0) ? ((rm == 6) ? 2 : 0) : (md == 1) ? 1 : (md == 2) ? 2 : 0;
               else        e.disp = (md == 0) ? ((rm == 5) ? 4 : 0) : (md == 1) ? 1 : (md == 2) ? 4 : 0;
               if (e.sib) i++;
            end
            i = i + e.disp + e.imm;
            if (i > n) break;
         end
         e.len = i - start;
         last_at[i-1] = 1'b1;
         exp_q.push_back(e);
      end
   endtask

   task automatic compare(exp_t e);
      chk("R9",  "length",        int'(out_len),       e.len);
      chk("R10", "error flag",    int'(out_err),       int'(e.err));
      chk("R3",  "prefix count",  int'(out_pfx_cnt),   e.pfx);
      chk("R3",  "lock",          int'(out_lock),      int'(e.lock));
      chk("R3",  "repeat",        int'(out_rep),       e.rep);
      chk("R3",  "segment",       int'(out_seg),       e.seg);
      chk("R3",  "operand size",  int'(out_opsz),      int'(e.opsz));
      chk("R3",  "address size",  int'(out_adsz),      int'(e.adsz));
      chk("R4",  "two-byte",      int'(out_two_byte),  int'(e.two));
      chk("R4",  "opcode",        int'(out_opcode),    e.opc);
      chk("R5",  "specifier",     int'(out_has_modrm), int'(e.modrm));
      chk("R6",  "scale-index",   int'(out_has_sib),   int'(e.sib));
      chk("R7",  "displacement",  int'(out_disp_len),  e.disp);
      chk("R8",  "immediate",     int'(out_imm_len),   e.imm);
   endtask

   initial begin
      int  idx;
      int  cyc;
      int  ndesc;
      bit  prev_last;
      bit  prev_hold;
      bit  acc;
      exp_t e;

      // Directed instructions
      push_bytes('{8'h90});
      push_bytes('{8'hF3, 8'h2E, 8'h66, 8'h67, 8'h0F, 8'h86, 8'h84, 8'h11, 8'h22, 8'h33, 8'h44});
      push_bytes('{8'h04, 8'h04, 8'h25});
      push_bytes('{8'h07, 8'h05, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06});
      push_bytes('{8'hF0, 8'hF0, 8'hF0, 8'hF0, 8'hF0});
      push_bytes('{8'h02, 8'hAA, 8'hBB, 8'hCC, 8'hDD});
      push_bytes('{8'h05, 8'hC4, 8'h7E});
      // Random stream biased toward prefixes
      for (int k = 0; k < RAND_BYTES; k++) begin
         if ($urandom % 4 == 0) begin
            case ($urandom % 11)
               0: stream.push_back(8'hF0);
               1: stream.push_back(8'hF2);
               2: stream.push_back(8'hF3);
               3: stream.push_back(8'h66);
               4: stream.push_back(8'h67);
               5: stream.push_back(8'h2E);
               6: stream.push_back(8'h36);
               7: stream.push_back(8'h3E);
               8: stream.push_back(8'h26);
               9: stream.push_back(8'h64);
               default: stream.push_back(8'h65);
            endcase
         end else if ($urandom % 10 == 0) begin
            stream.push_back(8'h0F);
         end else begin
            stream.push_back(8'($urandom));
         end
      end
      for (int k = 0; k < 20; k++) stream.push_back(8'h90);
      build_expect();

      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_data   = 8'h00;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "out_valid in reset", int'(out_valid), 0);
      chk("R1", "in_ready in reset",  int'(in_ready),  1);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1", "out_valid after reset", int'(out_valid), 0);
      chk("R1", "in_ready after reset",  int'(in_ready),  1);

      idx = 0; cyc = 0; ndesc = 0; prev_last = 1'b0; prev_hold = 1'b0;
      while ((idx < stream.size() || exp_q.size() > 0) && cyc < CYC_LIMIT) begin
         @(negedge clk);
         cyc++;
         in_valid  = (idx < stream.size()) && ($urandom % 4 != 0);
         in_data   = (idx < stream.size()) ? stream[idx] : 8'h00;
         out_ready = ($urandom % 3 != 0);
         #(CLK_PERIOD / 2 - 1);
         chk("R2", "in_ready", int'(in_ready), int'(!out_valid || out_ready));
         if (prev_last) chk("R11", "descriptor after last byte", int'(out_valid), 1);
         else if (prev_hold) chk("R2", "descriptor held", int'(out_valid), 1);
         else chk("R11", "no spurious descriptor", int'(out_valid), 0);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk("R9", "unexpected descriptor", 1, 0);
            end else begin
               e = exp_q.pop_front();
               compare(e);
               if (ndesc < DIR_N) chk("R9", "directed length", int'(out_len), DIR_LEN[ndesc]);
               if (ndesc == 4) chk("R10", "directed error", int'(out_err), 1);
               ndesc++;
            end
         end
         acc       = in_valid && in_ready;
         prev_last = acc && last_at[idx];
         prev_hold = out_valid && !out_ready;
         if (acc) idx++;
      end
      if (cyc >= CYC_LIMIT) begin
         tests_run++;
         tests_failed++;
         $display("FAIL R11 watchdog: actual %0d cycles expected fewer than %0d", cyc, CYC_LIMIT);
      end
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

endmodule